// File: doc/BRIEF.md
# Synchronous Serial Burst Engine with Inter-Byte Gap Control

This block runs a burst of one to eight bytes over a three-wire synchronous link as the clock master. It drives the serial clock and the serial data output and samples the serial data input. A start pulse latches the transmit bytes and the burst length. Each byte then goes out most significant bit first while the reply byte is shifted in over the same bits. Each received byte is written into its own slot of the receive buffer. The serial clock comes from the system clock through a programmable even divider: each half of a serial clock period lasts `half_div_i` system cycles.

Between two bytes of a burst the serial clock is held high for an idle gap. The gap is counted in system clock cycles and sized at the end of every byte. Its floor is the larger of five serial-clock half periods and a cycle count picked by a 2-bit activity class input. An optional programmed interval raises the gap further when it is the larger value. A busy flag covers the whole burst, and a one-cycle done pulse marks the end of the last byte.

Top module: `burst_sio`

## Requirements
- R1: After reset the serial clock output and the data output are high, and busy and done are low.
- R2: A start pulse is accepted only when the internal-clock enable is 1 and no burst is running. With the enable at 0, busy stays low and the serial clock stays high.
- R3: Each byte is driven on the data output most significant bit first. The data output changes only in the cycle where the serial clock falls. The data input is sampled when the serial clock rises, and byte k of the burst lands in bits [8k+7:8k] of `rx_data_o`. Transmit byte k is read from the same bit slice of `tx_data_i`.
- R4: The serial clock is low for H system cycles and high for H cycles within a byte, where H is `half_div_i`. A value of 0 is treated as 1.
- R5: Between bytes the serial clock stays high for G = max(5H, C) cycles. C depends on the activity class: 7 for code 00 (other), 13 for 01 (multiply), 20 for 10 (divide) and 9 for 11 (external access with one wait). The class is sampled at the last rising serial clock edge of each byte.
- R6: With the interval enable at 1, the gap is the larger of G and `ivl_val_i` cycles. With the enable at 0, `ivl_val_i` has no effect on the gap.
- R7: A burst sends `len_m1_i`+1 bytes. Busy rises in the cycle that accepts the start and falls at the last rising serial clock edge of the final byte. Done is high for exactly that one cycle.
- R8: A start pulse while busy is ignored. The running burst keeps its length and ends with a single done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System (CPU) clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| int_clk_en_i | input | 1 | Internal serial clock select; bursts run only when 1 |
| half_div_i | input | DIV_W | Serial clock half period in system cycles, latched at start |
| act_class_i | input | 2 | Activity class: 00 other, 01 multiply, 10 divide, 11 external wait |
| ivl_en_i | input | 1 | Enables the programmed interval |
| ivl_val_i | input | IVL_W | Programmed interval in system cycles |
| len_m1_i | input | IDX_W | Burst length minus one |
| tx_data_i | input | 8*DEPTH | Transmit bytes, byte k in bits [8k+7:8k] |
| start_i | input | 1 | Start pulse |
| si_i | input | 1 | Serial data input |
| sck_o | output | 1 | Serial clock, idles high |
| so_o | output | 1 | Serial data output |
| rx_data_o | output | 8*DEPTH | Received bytes, byte k in bits [8k+7:8k] |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse at the end of a burst |

## Verification
The hardest situation to reach from the ports is the gap selection, where three terms compete: the serial clock term, the activity term and the programmed interval. Each of them has to win in turn. The stimulus sweeps the divider and the activity class so that each class constant wins over 5H, and one divider setting lets 5H win instead. It also programs intervals above and below the activity term, and a large interval with the enable off. A bench-side slave model answers on the data input at every falling edge and records the data output at every rising edge. It also measures each high run of the serial clock after an eighth rising edge, which gives the gap cycle-exactly. A second start pulse is driven mid-burst to show that it is ignored.

// File: rtl/burst_sio_pkg.sv
package burst_sio_pkg;
  typedef enum logic [1:0] {
    ACT_OTHER = 2'b00,
    ACT_MUL   = 2'b01,
    ACT_DIV   = 2'b10,
    ACT_XWAIT = 2'b11
  } act_class_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_GAP
  } sio_state_t;

  localparam int CYC_OTHER = 7;
  localparam int CYC_MUL   = 13;
  localparam int CYC_DIV   = 20;
  localparam int CYC_XWAIT = 9;
endpackage

// File: rtl/burst_sio_gap.sv
module burst_sio_gap
  import burst_sio_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int IVL_W = 8,
  parameter int CNT_W = 11
) (
  input  logic [DIV_W-1:0] half_i,
  input  logic [1:0]       cls_i,
  input  logic             ivl_en_i,
  input  logic [IVL_W-1:0] ivl_val_i,
  output logic [CNT_W-1:0] gap_o
);
  logic [CNT_W-1:0] five_half;
  logic [CNT_W-1:0] act_cyc;
  logic [CNT_W-1:0] base_gap;
  logic [CNT_W-1:0] ivl_ext;

  assign five_half = CNT_W'({half_i, 2'b00}) + CNT_W'(half_i);
  assign ivl_ext   = CNT_W'(ivl_val_i);

  always_comb begin
    unique case (act_class_t'(cls_i))
      ACT_MUL:   act_cyc = CNT_W'(CYC_MUL);
      ACT_DIV:   act_cyc = CNT_W'(CYC_DIV);
      ACT_XWAIT: act_cyc = CNT_W'(CYC_XWAIT);
      default:   act_cyc = CNT_W'(CYC_OTHER);
    endcase
  end

  assign base_gap = (five_half > act_cyc) ? five_half : act_cyc;
  assign gap_o    = (ivl_en_i && ivl_ext > base_gap) ? ivl_ext : base_gap;
endmodule

// File: rtl/burst_sio_shift.sv
module burst_sio_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] load_byte_i,
  input  logic       fall_i,
  input  logic       rise_i,
  input  logic       si_i,
  output logic       so_o,
  output logic [7:0] rx_next_o
);
  logic [7:0] sr_q;

  assign rx_next_o = {sr_q[6:0], si_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
      so_o <= 1'b1;
    end else begin
      if (load_i)      sr_q <= load_byte_i;
      else if (rise_i) sr_q <= rx_next_o;
      // first fall of a burst coincides with the load
      if (fall_i)      so_o <= load_i ? load_byte_i[7] : sr_q[7];
    end
  end
endmodule

// File: rtl/burst_sio_buf.sv
module burst_sio_buf #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [8*DEPTH-1:0] tx_data_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [7:0]         tx_byte_o,
  input  logic               wr_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [7:0]         wr_byte_i,
  output logic [8*DEPTH-1:0] rx_data_o
);
  logic [DEPTH-1:0][7:0] tx_q;
  logic [DEPTH-1:0][7:0] rx_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tx_q[g] <= '0;
        rx_q[g] <= '0;
      end else begin
        if (load_i) tx_q[g] <= tx_data_i[8*g +: 8];
        if (wr_i && wr_idx_i == IDX_W'(g)) rx_q[g] <= wr_byte_i;
      end
    end
    assign rx_data_o[8*g +: 8] = rx_q[g];
  end

  assign tx_byte_o = tx_q[rd_idx_i];
endmodule

// File: rtl/burst_sio.sv
module burst_sio
  import burst_sio_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DIV_W = 8,
  parameter int IVL_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               int_clk_en_i,
  input  logic [DIV_W-1:0]   half_div_i,
  input  logic [1:0]         act_class_i,
  input  logic               ivl_en_i,
  input  logic [IVL_W-1:0]   ivl_val_i,
  input  logic [IDX_W-1:0]   len_m1_i,
  input  logic [8*DEPTH-1:0] tx_data_i,
  input  logic               start_i,
  input  logic               si_i,
  output logic               sck_o,
  output logic               so_o,
  output logic [8*DEPTH-1:0] rx_data_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int FIVE_W = DIV_W + 3;
  localparam int CNT_W  = (FIVE_W > IVL_W) ? FIVE_W : IVL_W;

  sio_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_q;
  logic [DIV_W-1:0] half_q;
  logic [DIV_W-1:0] half_eff;
  logic [CNT_W-1:0] gap_cyc;
  logic [CNT_W-1:0] half_reload;
  logic [7:0]       tx_next;
  logic [7:0]       rx_next;
  logic             accept;
  logic             cnt_zero;
  logic             fall_evt;
  logic             rise_evt;
  logic             byte_end;
  logic             burst_end;

  assign half_eff    = (half_div_i == '0) ? DIV_W'(1) : half_div_i;
  assign half_reload = CNT_W'(half_q - DIV_W'(1));
  assign accept      = start_i && int_clk_en_i && (state_q == ST_IDLE);
  assign cnt_zero    = (cnt_q == '0);
  assign rise_evt    = (state_q == ST_LOW) && cnt_zero;
  assign fall_evt    = accept || (((state_q == ST_HIGH) || (state_q == ST_GAP)) && cnt_zero);
  assign byte_end    = rise_evt && (bit_q == 3'd7);
  assign burst_end   = byte_end && (idx_q == last_q);

  burst_sio_gap #(
    .DIV_W(DIV_W),
    .IVL_W(IVL_W),
    .CNT_W(CNT_W)
  ) u_gap (
    .half_i   (half_q),
    .cls_i    (act_class_i),
    .ivl_en_i (ivl_en_i),
    .ivl_val_i(ivl_val_i),
    .gap_o    (gap_cyc)
  );

  burst_sio_buf #(
    .DEPTH(DEPTH),
    .IDX_W(IDX_W)
  ) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .tx_data_i(tx_data_i),
    .rd_idx_i (idx_q + IDX_W'(1)),
    .tx_byte_o(tx_next),
    .wr_i     (byte_end),
    .wr_idx_i (idx_q),
    .wr_byte_i(rx_next),
    .rx_data_o(rx_data_o)
  );

  burst_sio_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept || (byte_end && !burst_end)),
    .load_byte_i(accept ? tx_data_i[7:0] : tx_next),
    .fall_i     (fall_evt),
    .rise_i     (rise_evt),
    .si_i       (si_i),
    .so_o       (so_o),
    .rx_next_o  (rx_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      half_q  <= DIV_W'(1);
      sck_o   <= 1'b1;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_LOW;
          cnt_q   <= CNT_W'(half_eff - DIV_W'(1));
          half_q  <= half_eff;
          bit_q   <= '0;
          idx_q   <= '0;
          last_q  <= len_m1_i;
          sck_o   <= 1'b0;
          busy_o  <= 1'b1;
        end
        ST_LOW: begin
          if (cnt_zero) begin
            sck_o <= 1'b1;
            bit_q <= bit_q + 3'd1;
            if (burst_end) begin
              state_q <= ST_IDLE;
              busy_o  <= 1'b0;
              done_o  <= 1'b1;
            end else if (byte_end) begin
              // class and interval sampled here, gap starts at this rise
              state_q <= ST_GAP;
              cnt_q   <= gap_cyc - CNT_W'(1);
              idx_q   <= idx_q + IDX_W'(1);
            end else begin
              state_q <= ST_HIGH;
              cnt_q   <= half_reload;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: begin
          if (cnt_zero) begin
            state_q <= ST_LOW;
            sck_o   <= 1'b0;
            cnt_q   <= half_reload;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
      endcase
    end
  end

  p_idle_sck_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sck_o);
  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_ends_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_no_start_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !int_clk_en_i) |=> !busy_o);
  p_so_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(so_o) |-> $fell(sck_o));
  p_gap_sck_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |-> sck_o);
endmodule

// File: tb/burst_sio_tb.sv
`timescale 1ns/1ps
module burst_sio_tb;
  localparam int DEPTH = 8;
  localparam int DIV_W = 8;
  localparam int IVL_W = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               int_clk_en = 1'b0;
  logic [DIV_W-1:0]   half_div = 8'd1;
  logic [1:0]         act_class = 2'b00;
  logic               ivl_en = 1'b0;
  logic [IVL_W-1:0]   ivl_val = '0;
  logic [2:0]         len_m1 = '0;
  logic [8*DEPTH-1:0] tx_data = '0;
  logic               start = 1'b0;
  logic               si = 1'b0;
  logic               sck, so, busy, done;
  logic [8*DEPTH-1:0] rx_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // monitor state
  int   rise_cnt, fall_cnt, lo_run, lo_min, lo_max, hi_run, gap_idx, done_cnt, so_bad;
  bit   in_gap;
  int   gap_len [DEPTH];
  logic [7:0] cap [DEPTH];
  logic prev_sck = 1'b1;
  logic prev_so = 1'b1;

  always #4 clk = ~clk;

  burst_sio #(.DEPTH(DEPTH), .DIV_W(DIV_W), .IVL_W(IVL_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .int_clk_en_i(int_clk_en), .half_div_i(half_div),
    .act_class_i(act_class), .ivl_en_i(ivl_en), .ivl_val_i(ivl_val), .len_m1_i(len_m1),
    .tx_data_i(tx_data), .start_i(start), .si_i(si), .sck_o(sck), .so_o(so),
    .rx_data_o(rx_data), .busy_o(busy), .done_o(done)
  );

  function automatic logic [7:0] tx_pat(input int b);
    return 8'h3C ^ 8'(b * 8'h51);
  endfunction

  function automatic logic [7:0] sl_pat(input int b);
    return 8'hA5 + 8'(b * 8'h1D);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "WDOG", "watchdog expired", cyc, 150000);
      finish_run();
    end
    if (rst_n) begin
      if (!sck && prev_sck) begin
        if (in_gap) begin
          if (gap_idx < DEPTH) gap_len[gap_idx] = hi_run;
          gap_idx++;
          in_gap = 0;
        end
        si = sl_pat(fall_cnt / 8)[7 - (fall_cnt % 8)];
        fall_cnt++;
        lo_run = 1;
      end else if (!sck) begin
        lo_run++;
      end
      if (sck && !prev_sck) begin
        if (lo_run < lo_min) lo_min = lo_run;
        if (lo_run > lo_max) lo_max = lo_run;
        if (rise_cnt / 8 < DEPTH) cap[rise_cnt / 8][7 - (rise_cnt % 8)] = so;
        rise_cnt++;
        if (rise_cnt % 8 == 0) begin
          in_gap = 1;
          hi_run = 1;
        end
      end else if (sck && in_gap) begin
        hi_run++;
      end
      if (so !== prev_so && !(prev_sck && !sck)) so_bad++;
      if (done) done_cnt++;
    end
    prev_sck = sck;
    prev_so  = so;
  end

  task automatic clr_mon();
    rise_cnt = 0; fall_cnt = 0; lo_run = 0; lo_min = 1000; lo_max = 0;
    hi_run = 0; gap_idx = 0; done_cnt = 0; so_bad = 0; in_gap = 0;
    for (int i = 0; i < DEPTH; i++) begin
      gap_len[i] = -1;
      cap[i] = 'x;
    end
  endtask

  task automatic run_burst(input int h, input int n, input logic [1:0] cls, input logic en,
                           input int ivl, input int exp_gap, input bit poke, input string tag);
    int heff;
    int t;
    heff = (h == 0) ? 1 : h;
    @(negedge clk);
    clr_mon();
    int_clk_en = 1'b1;
    half_div = DIV_W'(h);
    act_class = cls;
    ivl_en = en;
    ivl_val = IVL_W'(ivl);
    len_m1 = 3'(n - 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R7", {tag, " busy after start"}, int'(busy), 1);
    chk(sck === 1'b0, "R3", {tag, " first fall at start"}, int'(sck), 0);
    t = 0;
    while (done_cnt == 0 && t < 20000) begin
      @(negedge clk);
      t++;
      start = (poke && t == 15) ? 1'b1 : 1'b0;
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R7", {tag, " done pulses"}, done_cnt, 1);
    chk(busy === 1'b0 && sck === 1'b1, "R7", {tag, " idle after burst"}, int'(busy), 0);
    chk(rise_cnt == 8 * n, poke ? "R8" : "R7", {tag, " clock rises"}, rise_cnt, 8 * n);
    chk(lo_min == heff && lo_max == heff, "R4", {tag, " low half length"}, lo_max, heff);
    chk(so_bad == 0, "R3", {tag, " so changed off falling edge"}, so_bad, 0);
    for (int b = 0; b < n; b++) begin
      chk(cap[b] === tx_pat(b), "R3", {tag, " so byte msb first"}, int'(cap[b]), int'(tx_pat(b)));
      chk(rx_data[8*b +: 8] === sl_pat(b), "R3", {tag, " rx byte slot"},
          int'(rx_data[8*b +: 8]), int'(sl_pat(b)));
    end
    for (int b = 0; b < n - 1; b++)
      chk(gap_len[b] == exp_gap, en ? "R6" : "R5", {tag, " inter-byte gap"}, gap_len[b], exp_gap);
  endtask

  initial begin
    for (int b = 0; b < DEPTH; b++) tx_data[8*b +: 8] = tx_pat(b);
    clr_mon();
    repeat (3) @(negedge clk);
    chk(sck === 1'b1 && so === 1'b1, "R1", "reset sck/so", int'({sck, so}), 3);
    chk(busy === 1'b0 && done === 1'b0, "R1", "reset busy/done", int'({busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: start ignored with internal clock deselected
    int_clk_en = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy === 1'b0 && sck === 1'b1 && rise_cnt == 0, "R2", "gated start", rise_cnt, 0);

    run_burst(2, 3, 2'b00, 1'b0, 0, 10, 1'b0, "h2 other");
    run_burst(1, 2, 2'b01, 1'b0, 0, 13, 1'b0, "mul");
    run_burst(1, 2, 2'b10, 1'b0, 0, 20, 1'b0, "div");
    run_burst(1, 2, 2'b11, 1'b0, 0, 9, 1'b0, "xwait");
    run_burst(1, 2, 2'b00, 1'b0, 0, 7, 1'b0, "other");
    run_burst(3, 2, 2'b00, 1'b0, 0, 15, 1'b0, "h3 sck wins");
    run_burst(0, 2, 2'b00, 1'b0, 0, 7, 1'b0, "h0 as 1");
    run_burst(1, 2, 2'b00, 1'b1, 30, 30, 1'b0, "ivl wins");
    run_burst(1, 2, 2'b00, 1'b1, 3, 7, 1'b0, "ivl small");
    run_burst(1, 2, 2'b00, 1'b0, 50, 7, 1'b0, "ivl disabled");
    run_burst(1, 8, 2'b10, 1'b0, 0, 20, 1'b0, "full depth");
    run_burst(2, 1, 2'b01, 1'b0, 0, 0, 1'b0, "single byte");
    run_burst(1, 3, 2'b00, 1'b0, 0, 7, 1'b1, "start while busy");
    finish_run();
  end
endmodule